// File: doc/BRIEF.md
# Standby Entry and Wake-Up Controller

This block sequences a processor's low-power transitions. A small control register selects what the CPU's sleep instruction does: a light sleep, in which only the CPU clock stops, or a deep standby, in which every internal clock stops. A pulse on `sleep_req` from the CPU starts the chosen transition. An interrupt ends a light sleep at once. An external interrupt ends deep standby, and is followed by a settling wait: a counter runs on the oscillator for a programmable number of clock states, and clocks return only when it finishes.

The same register chooses how the external bus behaves in standby. The address bus and the bus strobes can float. The other choice keeps the address bus at its last driven value and forces every strobe to its inactive high level. A reserved wait code is run as the longest wait, and it raises a sticky error flag.

The parameter `WAIT_SHIFT` divides every wait length by 2^WAIT_SHIFT, so that scaled-down runs are possible. The default of 0 gives the full lengths.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `mode_o` is active (00), both clock enables are 1, `resume_pulse` is 0 and the bus outputs follow the CPU with their output enables at 1.
- R2: Register layout as read and written: bit 7 is the standby select, bits 6:4 are the wait code, bit 1 is the bus-hold enable, and bit 0 is the read-only error flag. Bits 3:2 read as 0.
- R3: A `sleep_req` sampled in the active state while the standby select is 0 moves `mode_o` to sleep (01) on the next clock. In sleep, `cpu_clk_en` is 0 and `periph_clk_en` is 1.
- R4: `irq_wake` sampled in sleep returns `mode_o` to active on the next clock, with no settling wait and no `resume_pulse`.
- R5: A `sleep_req` sampled in the active state while the standby select is 1 moves `mode_o` to standby (10) on the next clock. In standby both clock enables are 0.
- R6: `irq_wake` sampled in standby moves `mode_o` to settling (11). `cpu_clk_en` returns to 1 exactly N clocks after that sampling edge. `resume_pulse` is high for that one cycle only.
- R7: N depends on the wait code, divided by 2^WAIT_SHIFT. Code 000 gives 8192, 001 gives 16384, 010 gives 32768, 011 gives 65536, 100 gives 131072, 101 gives 262144 and 110 gives 1024.
- R8: Wait code 111 is reserved. It is run as 262144 states. Writing it sets the error flag (bit 0), which stays set until reset.
- R9: The standby select stays 1 after a wake from standby, and only a write of 0 clears it.
- R10: With bus-hold at 0, `bus_addr_oe` and `bus_strobe_oe` are 0 in standby and in settling.
- R11: With bus-hold at 1, during standby and settling `bus_addr` holds the address last driven before entry, `bus_strobes` are all 1, and both output enables stay 1.
- R12: `irq_wake` has no effect in the active state, and `sleep_req` has no effect outside the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sleep_req | input | 1 | CPU executed its sleep instruction |
| irq_wake | input | 1 | Wake-up interrupt request |
| cpu_addr | input | ADDR_W | Address driven by the CPU |
| cpu_strobes | input | STRB_W | Chip selects and bus strobes from the CPU |
| bus_addr | output | ADDR_W | Address toward the pads |
| bus_addr_oe | output | 1 | Address pad output enable |
| bus_strobes | output | STRB_W | Strobes toward the pads |
| bus_strobe_oe | output | 1 | Strobe pad output enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| resume_pulse | output | 1 | One-cycle pulse when a standby wake completes |
| mode_o | output | 2 | 00 active, 01 sleep, 10 standby, 11 settling |
| cfg_err | output | 1 | Sticky reserved-code error flag |

## Verification
A countdown that is loaded wrong, or that takes the wrong branch, changes the cycle on which `cpu_clk_en` and `resume_pulse` return. The bench counts clocks from the waking edge for every legal code and for the reserved code, so a single-cycle slip shows on the compare at the end of the wait. A wrong mode transition shows on `mode_o` and on the clock enables one clock after the stimulus. A missing hold register or a wrong pad enable shows on the bus outputs during the first standby cycle.

// File: rtl/pwr_standby_pkg.sv
// Package: shared types of the standby controller.
// Assumes: mode codes are visible on the mode_o port, so their values are fixed.
package pwr_standby_pkg;
    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'b00,
        MODE_SLEEP   = 2'b01,
        MODE_STANDBY = 2'b10,
        MODE_SETTLE  = 2'b11
    } pwr_mode_e;

    localparam int WAIT_MAX_LOG = 18;   // log2 of the longest wait in states
    localparam logic [2:0] WAIT_CODE_RSVD = 3'b111;
endpackage

// File: rtl/pwr_standby_regs.sv
// Control register of the standby controller.
// Holds the standby select, the wait code, the bus-hold enable and the sticky
// error flag. Assumes writes can arrive in any mode; the select is never
// cleared by hardware.
module pwr_standby_regs
    import pwr_standby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       stby_sel,
    output logic [2:0] wait_code,
    output logic       bus_hold,
    output logic       cfg_err
);
    logic       sel_q;
    logic [2:0] code_q;
    logic       hold_q;
    logic       err_q;

    // Capture writable fields; the error flag only ever sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            code_q <= 3'b000;
            hold_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (reg_we) begin
            sel_q  <= reg_wdata[7];
            code_q <= reg_wdata[6:4];
            hold_q <= reg_wdata[1];
            if (reg_wdata[6:4] == WAIT_CODE_RSVD) begin
                err_q <= 1'b1;
            end
        end
    end

    // Assemble the read view.
    always_comb begin
        reg_rdata = {sel_q, code_q, 2'b00, hold_q, err_q};
    end

    assign stby_sel  = sel_q;
    assign wait_code = code_q;
    assign bus_hold  = hold_q;
    assign cfg_err   = err_q;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/pwr_wait_decode.sv
// Turns the 3-bit wait code into a settling length in clock states.
// Lengths are divided by 2^WAIT_SHIFT. The reserved code maps to the longest
// length. Assumes WAIT_SHIFT <= 10, so that every length is at least one state.
module pwr_wait_decode
    import pwr_standby_pkg::*;
#(
    parameter int WAIT_SHIFT = 0,
    parameter int CNT_W      = WAIT_MAX_LOG - WAIT_SHIFT + 1
) (
    input  logic [2:0]       wait_code,
    output logic [CNT_W-1:0] wait_len
);
    logic [4:0] lg;

    // Pick log2 of the length for the code.
    always_comb begin
        case (wait_code)
            3'b000:  lg = 5'd13;
            3'b001:  lg = 5'd14;
            3'b010:  lg = 5'd15;
            3'b011:  lg = 5'd16;
            3'b100:  lg = 5'd17;
            3'b101:  lg = 5'd18;
            3'b110:  lg = 5'd10;
            default: lg = 5'd18;
        endcase
    end

    // Scale and expand to a one-hot length.
    always_comb begin
        wait_len = CNT_W'(1) << (lg - 5'(WAIT_SHIFT));
    end

    // Decoded length is always a single power of two.
    always_comb begin
        assert_len_onehot_R7: assert ($onehot(wait_len));
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
// Low-power mode sequencer with the settling countdown.
// Enters sleep or standby on sleep_req and leaves on irq_wake. After a
// standby wake it counts wait_len states before it returns to active.
// Assumes clk keeps running in every mode (it is the oscillator).
module pwr_mode_fsm
    import pwr_standby_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             irq_wake,
    input  logic             stby_sel,
    input  logic [CNT_W-1:0] wait_len,
    output pwr_mode_e        mode,
    output logic             resume_pulse
);
    pwr_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             resume_q;

    // Mode transitions, countdown and the resume pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_ACTIVE;
            cnt_q    <= '0;
            resume_q <= 1'b0;
        end else begin
            resume_q <= 1'b0;
            case (mode_q)
                MODE_ACTIVE: begin
                    if (sleep_req) begin
                        mode_q <= stby_sel ? MODE_STANDBY : MODE_SLEEP;
                    end
                end
                MODE_SLEEP: begin
                    if (irq_wake) begin
                        mode_q <= MODE_ACTIVE;
                    end
                end
                MODE_STANDBY: begin
                    if (irq_wake) begin
                        mode_q <= MODE_SETTLE;
                        cnt_q  <= wait_len - CNT_W'(1);
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        mode_q   <= MODE_ACTIVE;
                        resume_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign mode         = mode_q;
    assign resume_pulse = resume_q;

    assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ACTIVE && sleep_req && !stby_sel) |=> (mode_q == MODE_SLEEP));
    assert_stby_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ACTIVE && sleep_req && stby_sel) |=> (mode_q == MODE_STANDBY));
    assert_settle_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SETTLE && cnt_q != '0) |=>
        (mode_q == MODE_SETTLE && cnt_q == $past(cnt_q) - CNT_W'(1)));
    assert_resume_after_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |-> ($past(mode_q) == MODE_SETTLE && mode_q == MODE_ACTIVE));
    assert_irq_ignored_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ACTIVE && !sleep_req) |=> (mode_q == MODE_ACTIVE));
endmodule

// File: rtl/pwr_bus_ctrl.sv
// Pad-side bus behaviour in standby.
// Passes the CPU address and strobes through outside standby. In standby and
// settling it either floats both groups or holds the last address and drives
// every strobe high. Assumes strobes are active low.
module pwr_bus_ctrl
    import pwr_standby_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int STRB_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pwr_mode_e         mode,
    input  logic              bus_hold,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [STRB_W-1:0] cpu_strobes,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_oe,
    output logic [STRB_W-1:0] bus_strobes,
    output logic              bus_strobe_oe
);
    logic              in_stby;
    logic [ADDR_W-1:0] addr_q;

    assign in_stby = (mode == MODE_STANDBY) || (mode == MODE_SETTLE);

    // Track the address while the bus runs; freeze it in standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!in_stby) begin
            addr_q <= cpu_addr;
        end
    end

    // Select pad values and enables for the current mode.
    always_comb begin
        if (!in_stby) begin
            bus_addr      = cpu_addr;
            bus_strobes   = cpu_strobes;
            bus_addr_oe   = 1'b1;
            bus_strobe_oe = 1'b1;
        end else begin
            bus_addr      = addr_q;
            bus_strobes   = '1;
            bus_addr_oe   = bus_hold;
            bus_strobe_oe = bus_hold;
        end
    end

    assert_addr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stby && $past(in_stby)) |-> $stable(bus_addr));
    assert_float_in_stby_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STANDBY && !bus_hold) |-> (!bus_addr_oe && !bus_strobe_oe));
endmodule

// File: rtl/pwr_standby_ctrl.sv
// Top of the standby entry and wake-up controller.
// Connects the control register, the wait decoder, the mode sequencer and
// the bus pad control, and derives the clock enables from the mode.
// Assumes sleep_req is a one-cycle pulse and irq_wake is already masked.
module pwr_standby_ctrl
    import pwr_standby_pkg::*;
#(
    parameter int WAIT_SHIFT = 0,
    parameter int ADDR_W     = 24,
    parameter int STRB_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sleep_req,
    input  logic              irq_wake,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [STRB_W-1:0] cpu_strobes,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_oe,
    output logic [STRB_W-1:0] bus_strobes,
    output logic              bus_strobe_oe,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              resume_pulse,
    output logic [1:0]        mode_o,
    output logic              cfg_err
);
    localparam int CNT_W = WAIT_MAX_LOG - WAIT_SHIFT + 1;

    logic             stby_sel;
    logic [2:0]       wait_code;
    logic             bus_hold;
    logic [CNT_W-1:0] wait_len;
    pwr_mode_e        mode;

    pwr_standby_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .stby_sel  (stby_sel),
        .wait_code (wait_code),
        .bus_hold  (bus_hold),
        .cfg_err   (cfg_err)
    );

    pwr_wait_decode #(.WAIT_SHIFT(WAIT_SHIFT), .CNT_W(CNT_W)) u_dec (
        .wait_code (wait_code),
        .wait_len  (wait_len)
    );

    pwr_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .irq_wake     (irq_wake),
        .stby_sel     (stby_sel),
        .wait_len     (wait_len),
        .mode         (mode),
        .resume_pulse (resume_pulse)
    );

    pwr_bus_ctrl #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .bus_hold      (bus_hold),
        .cpu_addr      (cpu_addr),
        .cpu_strobes   (cpu_strobes),
        .bus_addr      (bus_addr),
        .bus_addr_oe   (bus_addr_oe),
        .bus_strobes   (bus_strobes),
        .bus_strobe_oe (bus_strobe_oe)
    );

    // Clock enables follow the mode: CPU only when active, peripherals also in sleep.
    always_comb begin
        cpu_clk_en    = (mode == MODE_ACTIVE);
        periph_clk_en = (mode == MODE_ACTIVE) || (mode == MODE_SLEEP);
        mode_o        = mode;
    end

    assert_stby_clocks_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[1] == 1'b1) |-> (!cpu_clk_en && !periph_clk_en));
endmodule

// File: tb/pwr_standby_ctrl_tb.sv
// Bench for the standby controller: a table of wait codes with expected
// lengths walked by one loop, then directed tests.
module pwr_standby_ctrl_tb_top;
    localparam int SHIFT  = 4;
    localparam int ADDR_W = 24;
    localparam int STRB_W = 12;
    localparam int NVEC   = 7;

    localparam logic [2:0] VEC_CODE [NVEC] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                               3'b100, 3'b101, 3'b110};
    localparam int VEC_LEN [NVEC] = '{8192 >> SHIFT, 16384 >> SHIFT, 32768 >> SHIFT,
                                      65536 >> SHIFT, 131072 >> SHIFT, 262144 >> SHIFT,
                                      1024 >> SHIFT};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              sleep_req = 1'b0;
    logic              irq_wake = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [STRB_W-1:0] cpu_strobes = '0;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_addr_oe;
    logic [STRB_W-1:0] bus_strobes;
    logic              bus_strobe_oe;
    logic              cpu_clk_en;
    logic              periph_clk_en;
    logic              resume_pulse;
    logic [1:0]        mode_o;
    logic              cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwr_standby_ctrl #(.WAIT_SHIFT(SHIFT), .ADDR_W(ADDR_W), .STRB_W(STRB_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .irq_wake(irq_wake),
        .cpu_addr(cpu_addr), .cpu_strobes(cpu_strobes), .bus_addr(bus_addr),
        .bus_addr_oe(bus_addr_oe), .bus_strobes(bus_strobes),
        .bus_strobe_oe(bus_strobe_oe), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .resume_pulse(resume_pulse),
        .mode_o(mode_o), .cfg_err(cfg_err)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d; step(); reg_we = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
    endtask

    // Wake from standby and check the exact return cycle of cpu_clk_en.
    task automatic wake_and_time(input int n, input string req);
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
        chk(32'(mode_o), 32'd3, req);
        repeat (n - 1) step();
        chk({30'd0, cpu_clk_en, resume_pulse}, 32'd0, req);
        step();
        chk({28'd0, mode_o, cpu_clk_en, resume_pulse}, 32'b0011, req);
        step();
        chk(32'(resume_pulse), 32'd0, req);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        cpu_addr = 24'h00A5C3; cpu_strobes = 12'h3F0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk(32'(reg_rdata), 32'h00, "R1");
        chk({26'd0, mode_o, cpu_clk_en, periph_clk_en, resume_pulse, cfg_err},
            32'b001100, "R1");
        chk({bus_addr, 6'd0, bus_addr_oe, bus_strobe_oe}, {24'h00A5C3, 8'h03}, "R1");
        chk(32'(bus_strobes), 32'h3F0, "R1");

        // R2: register layout, bits 3:2 read 0
        wr(8'hAE);
        chk(32'(reg_rdata), 32'hA2, "R2");

        // Table walk: R6/R7 exact wake timing per legal code
        for (int i = 0; i < NVEC; i++) begin
            wr({1'b1, VEC_CODE[i], 4'b0000});
            pulse_sleep();
            chk({28'd0, mode_o, cpu_clk_en, periph_clk_en}, 32'b1000, "R5");
            wake_and_time(VEC_LEN[i], "R7");
        end

        // R9: select survives wake; write 0 clears it
        chk(32'(reg_rdata[7]), 32'd1, "R9");
        wr(8'h60);
        chk(32'(reg_rdata[7]), 32'd0, "R9");

        // R3/R4: light sleep and immediate return
        pulse_sleep();
        chk({28'd0, mode_o, cpu_clk_en, periph_clk_en}, 32'b0101, "R3");
        sleep_req = 1'b1; step(); sleep_req = 1'b0;   // R12: ignored in sleep
        chk(32'(mode_o), 32'd1, "R12");
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
        chk({28'd0, mode_o, cpu_clk_en, resume_pulse}, 32'b0010, "R4");

        // R12: irq in active has no effect
        irq_wake = 1'b1; step(); step(); irq_wake = 1'b0;
        chk({28'd0, mode_o, cpu_clk_en, periph_clk_en}, 32'b0011, "R12");

        // R8: reserved code acts as the longest wait and sets a sticky error
        chk(32'(cfg_err), 32'd0, "R8");
        wr(8'hF0);
        chk({24'd0, reg_rdata}, 32'hF1, "R8");
        pulse_sleep();
        wake_and_time(262144 >> SHIFT, "R8");
        wr(8'h80);
        chk({31'd0, cfg_err}, 32'd1, "R8");

        // R10: floating bus in standby and settling
        pulse_sleep();
        chk({30'd0, bus_addr_oe, bus_strobe_oe}, 32'd0, "R10");
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
        chk({28'd0, mode_o, bus_addr_oe, bus_strobe_oe}, 32'b1100, "R10");
        repeat (8192 >> SHIFT) step();
        chk({28'd0, mode_o, bus_addr_oe, bus_strobe_oe}, 32'b0011, "R10");

        // R11: hold address, strobes forced high
        wr(8'h82);
        cpu_addr = 24'h123456; step();
        pulse_sleep();
        cpu_addr = 24'hFEDCBA; cpu_strobes = 12'h000; step();
        chk(32'(bus_addr), 32'h123456, "R11");
        chk({bus_strobes, 18'd0, bus_addr_oe, bus_strobe_oe}, {12'hFFF, 20'h3}, "R11");
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
        chk(32'(bus_addr), 32'h123456, "R11");
        repeat (8192 >> SHIFT) step();
        chk({bus_addr, 8'(bus_strobes)}, {24'hFEDCBA, 8'h00}, "R11");

        // R1: reset restores defaults after activity
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        chk({23'd0, reg_rdata, cfg_err}, 32'd0, "R1");

        done = 1'b1;
        report();
    end
endmodule